// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns a single start request into the series of column addresses that one synchronous DRAM burst visits. On each request the caller supplies the first column, a three-bit length code and a type select (linear or interleaved). The block then presents one column per clock with a valid strobe, and marks the final column of a fixed-length burst with a last-beat strobe.

For a burst of N beats, the column bits above log2(N) are held from the start column. Only the low log2(N) bits move inside that aligned block. In linear order they count up modulo N. In interleaved order they are the start offset XOR the beat number. A whole-row mode counts through all 256 columns and wraps from 255 back to 0. It runs until a terminate input stops it, and a terminate input can also cut a fixed-length burst short. Command sequencing and data movement are handled by neighbouring logic.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `valid_o`, `last_o` and `err_o` are low.
- R2: With `valid_o` low, a high `start_i` carrying length code 000, 001, 010 or 011 produces 1, 2, 4 or 8 beats. The beats fall on consecutive cycles, and the first one appears on the cycle after `start_i` was sampled.
- R3: Every column of a fixed burst of N beats keeps bits [7:log2(N)] of the start column.
- R4: When `ilv_i`=0, beat i of an N-beat burst has low bits (s+i) mod N, where s is the start column's low log2(N) bits. For example, N=4 starting at offset 1 gives 1,2,3,0.
- R5: When `ilv_i`=1, beat i has low bits s XOR i. For example, N=8 starting at 5 gives 5,4,7,6,1,0,3,2.
- R6: With length code 000, exactly one beat carrying the start column is produced, whatever `ilv_i` is.
- R7: Length code 111 with `ilv_i`=0 selects whole-row mode. Beats start at the given column, advance by one per cycle and wrap from 255 to 0. `last_o` never rises in this mode, and the burst continues until it is terminated.
- R8: For fixed lengths, `last_o` is high on beat N-1 and only then. `valid_o` is low on the following cycle unless a new burst is started.
- R9: When `term_i` is high on a cycle where `valid_o` is high, `valid_o` is low on the next cycle.
- R10: A start carrying length code 100, 101 or 110, or code 111 with `ilv_i`=1, produces no beats. Instead `err_o` goes high for exactly the next cycle.
- R11: A `start_i` pulse that arrives while `valid_o` is high has no effect on the running burst's columns or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a new burst (taken only while idle) |
| col_i | input | 8 | First column of the burst |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = linear order |
| term_i | input | 1 | Stop the running burst after the current beat |
| col_o | output | 8 | Column for the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Final beat of a fixed-length burst |
| err_o | output | 1 | One-cycle flag for a rejected request |

## Verification
The bench builds the block with its default 8-bit column width. This makes the whole-row mode exactly 256 beats long, so a run of more than 256 beats can be watched wrapping from 255 to 0 without `last_o` ever rising. Starting columns are placed in high aligned blocks (such as 0xF5 and 0x41) so that preserving the upper bits is visible. Every start offset within a block, in both orders, is reachable from the same build.

// File: rtl/burst_col_seq_pkg.sv
package burst_col_seq_pkg;
  localparam int unsigned LEN_CODE_W = 3;
  localparam logic [LEN_CODE_W-1:0] LEN_ROW = 3'b111;
  localparam logic [LEN_CODE_W-1:0] LEN_MAX_FIXED = 3'b011;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode
  import burst_col_seq_pkg::*;
#(
  parameter int unsigned COL_W = 8,
  parameter int unsigned LG_W  = $clog2(COL_W + 1)
) (
  input  logic [LEN_CODE_W-1:0] code_i,
  input  logic                  ilv_i,
  output logic                  ok_o,
  output logic                  row_o,
  output logic [LG_W-1:0]       lg2_o
);
  always_comb begin
    ok_o  = 1'b0;
    row_o = 1'b0;
    lg2_o = '0;
    if (code_i <= LEN_MAX_FIXED) begin
      ok_o  = 1'b1;
      lg2_o = LG_W'(code_i);
    end else if (code_i == LEN_ROW) begin
      ok_o  = ~ilv_i;
      row_o = 1'b1;
      lg2_o = LG_W'(COL_W);
    end
  end
endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen #(
  parameter int unsigned COL_W = 8,
  parameter int unsigned LG_W  = $clog2(COL_W + 1)
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [LG_W-1:0]  lg2_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o,
  output logic [COL_W-1:0] mask_o
);
  logic [COL_W-1:0] lin_sum;
  logic [COL_W-1:0] xor_val;
  logic [COL_W-1:0] low_bits;

  always_comb begin
    mask_o   = ~({COL_W{1'b1}} << lg2_i);
    lin_sum  = base_i + beat_i;
    xor_val  = base_i ^ beat_i;
    low_bits = ilv_i ? xor_val : lin_sum;
    col_o    = (base_i & ~mask_o) | (low_bits & mask_o);
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_seq_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  ilv_i,
  input  logic                  term_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  valid_o,
  output logic                  last_o,
  output logic                  err_o
);
  localparam int unsigned LG_W = $clog2(COL_W + 1);

  seq_state_e       state_q, state_d;
  logic [COL_W-1:0] base_q, beat_q, beat_d;
  logic [LG_W-1:0]  lg2_q;
  logic             ilv_q, row_q, err_q, err_d;

  logic             dec_ok, dec_row;
  logic [LG_W-1:0]  dec_lg2;
  logic [COL_W-1:0] gen_mask;
  logic             load_en, adv_en, at_end;

  bcs_len_decode #(.COL_W(COL_W), .LG_W(LG_W)) u_dec (
    .code_i (len_code_i),
    .ilv_i  (ilv_i),
    .ok_o   (dec_ok),
    .row_o  (dec_row),
    .lg2_o  (dec_lg2)
  );

  bcs_col_gen #(.COL_W(COL_W), .LG_W(LG_W)) u_gen (
    .base_i (base_q),
    .beat_i (beat_q),
    .lg2_i  (lg2_q),
    .ilv_i  (ilv_q),
    .col_o  (col_o),
    .mask_o (gen_mask)
  );

  assign at_end = ~row_q & (beat_q == gen_mask);

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    err_d   = 1'b0;
    load_en = 1'b0;
    adv_en  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_i) begin
          if (dec_ok) begin
            state_d = SEQ_RUN;
            beat_d  = '0;
            load_en = 1'b1;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      SEQ_RUN: begin
        if (term_i || at_end) begin
          state_d = SEQ_IDLE;
        end else begin
          adv_en = 1'b1;
          beat_d = beat_q + 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      beat_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (load_en || adv_en) beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      lg2_q  <= '0;
      ilv_q  <= 1'b0;
      row_q  <= 1'b0;
    end else if (load_en) begin
      base_q <= col_i;
      lg2_q  <= dec_lg2;
      ilv_q  <= ilv_i;
      row_q  <= dec_row;
    end
  end

  assign valid_o = (state_q == SEQ_RUN);
  assign last_o  = valid_o & at_end;
  assign err_o   = err_q;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic term_i,
  input logic valid_o,
  input logic last_o,
  input logic err_o
);
  // R8
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  // R8
  last_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && last_o) |=> !valid_o);

  // R9
  term_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && term_i) |=> !valid_o);

  // R2
  beats_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o && !term_i) |=> valid_o);

  // R10
  err_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !valid_o);

  // R10
  err_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  // R11
  busy_start_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && start_i && !last_o && !term_i) |=> (valid_o && !err_o));
endmodule

bind burst_col_seq burst_col_seq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .term_i  (term_i),
  .valid_o (valid_o),
  .last_o  (last_o),
  .err_o   (err_o)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] col_i = '0;
  logic [2:0] len_code_i = '0;
  logic       ilv_i = 1'b0;
  logic       term_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o, last_o, err_o;

  int n_checks = 0;
  int n_fail = 0;
  string tag = "R1";
  bit done = 1'b0;

  // behavioural reference model
  bit  m_busy = 0, m_row = 0, m_err = 0;
  int  m_col = 0;
  int  m_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
    .len_code_i(len_code_i), .ilv_i(ilv_i), .term_i(term_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_row = 0; m_err = 0; m_q.delete();
    end else if (m_busy) begin
      m_err = 0;
      if (term_i || (!m_row && m_q.size() == 1)) begin
        m_busy = 0; m_q.delete();
      end else if (m_row) begin
        m_col = (m_col + 1) % 256;
      end else begin
        void'(m_q.pop_front());
      end
    end else if (start_i) begin
      int n;
      n = 0;
      m_err = 0;
      case (len_code_i)
        3'b000: n = 1;
        3'b001: n = 2;
        3'b010: n = 4;
        3'b011: n = 8;
        3'b111: n = ilv_i ? 0 : 256;
        default: n = 0;
      endcase
      if (n == 0) begin
        m_err = 1;
      end else if (n == 256) begin
        m_busy = 1; m_row = 1; m_col = int'(col_i);
      end else begin
        int blk, off;
        blk = int'(col_i) - (int'(col_i) % n);
        off = int'(col_i) % n;
        m_busy = 1; m_row = 0;
        for (int i = 0; i < n; i++)
          m_q.push_back(blk + (ilv_i ? (off ^ i) : ((off + i) % n)));
      end
    end else begin
      m_err = 0;
    end
  end

  task automatic check(string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("valid", int'(valid_o), int'(m_busy));
      check("err", int'(err_o), int'(m_err));
      check("last", int'(last_o), int'(m_busy && !m_row && m_q.size() == 1));
      if (m_busy) check("col", int'(col_o), m_row ? m_col : m_q[0]);
    end
  end

  task automatic go(input logic [7:0] c, input logic [2:0] code, input logic ilv);
    @(negedge clk);
    start_i = 1'b1; col_i = c; len_code_i = code; ilv_i = ilv;
    @(negedge clk);
    start_i = 1'b0; col_i = ~c; len_code_i = 3'b101; ilv_i = ~ilv;
  endtask

  task automatic drain();
    while (valid_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic stop_after(input int beats);
    repeat (beats - 1) @(negedge clk);
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    check("reset valid", int'(valid_o), 0);
    check("reset last", int'(last_o), 0);
    check("reset err", int'(err_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("post-reset valid", int'(valid_o), 0);

    tag = "R4"; go(8'h41, 3'b010, 1'b0); drain();
    tag = "R3"; go(8'hF5, 3'b011, 1'b0); drain();
    tag = "R2"; go(8'h33, 3'b001, 1'b0); drain();
    tag = "R5"; go(8'hA5, 3'b011, 1'b1); drain();
    tag = "R5"; go(8'h0B, 3'b010, 1'b1); drain();
    tag = "R5"; go(8'h7F, 3'b001, 1'b1); drain();
    tag = "R6"; go(8'h9C, 3'b000, 1'b0); drain();
    tag = "R6"; go(8'h9D, 3'b000, 1'b1); drain();
    tag = "R8"; go(8'h12, 3'b011, 1'b0); drain();
    tag = "R7"; go(8'hFD, 3'b111, 1'b0); stop_after(6); drain();
    tag = "R7"; go(8'h00, 3'b111, 1'b0); stop_after(300); drain();
    tag = "R9"; go(8'h28, 3'b011, 1'b0); stop_after(3); drain();
    tag = "R9"; go(8'h28, 3'b010, 1'b1); stop_after(1); drain();
    tag = "R10"; go(8'h10, 3'b100, 1'b0); drain();
    tag = "R10"; go(8'h10, 3'b101, 1'b1); drain();
    tag = "R10"; go(8'h10, 3'b110, 1'b0); drain();
    tag = "R10"; go(8'h10, 3'b111, 1'b1); drain();
    tag = "R11";
    go(8'h63, 3'b011, 1'b1);
    @(negedge clk);
    start_i = 1'b1; col_i = 8'h00; len_code_i = 3'b111; ilv_i = 1'b0;
    @(negedge clk);
    start_i = 1'b1; len_code_i = 3'b100;
    @(negedge clk);
    start_i = 1'b0;
    drain();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule